// File: doc/BRIEF.md
# Fixed-Rate Converter Sample Sequencer

This block sets the sampling instant of a serial successive-approximation ADC and the update instant of a serial DAC. Both come from one counter on the system clock, so their period is a whole number of cycles and is the same for every sample. On each sample strobe the block pulls the ADC chip select low, which puts the converter into hold. It then runs a slower conversion clock through a short lead-in and the data bits, and places the finished result in a read register that software can collect at any time. In the same cycle it pulses the DAC load line, which updates the analog output with the word sent during the previous period. It then starts sending the most recently written DAC word.

The conversion clock and the DAC serial clock are generated on their own and only need to be a fixed multiple of the system clock. Their phase relative to the strobe is not critical. The processor side has no timing duties. It reads a result when a valid flag is up, and an overrun flag tells it that it fell behind. It writes the next DAC word whenever it likes. If it writes nothing, the previous word is sent again.

Top module: `fixed_rate_sampler`

## Requirements
- R1: `sampleStb` is a one-cycle pulse that repeats every SAMPLE_DIV system clocks (default 1000), with no variation between periods.
- R2: While `rstN` is low: both chip selects are high, both serial clocks are low, `sampleStb`, `dacLoad`, `rdValid` and `rdOverrun` are low, and `rdData` is zero.
- R3: `adcCsN` falls in the same cycle as `sampleStb` and stays low for exactly (ADC_LEAD+ADC_BITS)×CONV_DIV cycles (default 21×16 = 336). It is high again before the next strobe.
- R4: While `adcCsN` is low, `adcSclk` has a period of CONV_DIV cycles, starts low, and gives exactly ADC_LEAD+ADC_BITS rising edges (default 21). While `adcCsN` is high, `adcSclk` stays low.
- R5: The result is formed from `adcSdo` sampled at the falling edges of conversion clocks ADC_LEAD+1 to ADC_LEAD+ADC_BITS (default 6 to 21), with the first one as the MSB. The levels on `adcSdo` during the first ADC_LEAD clocks have no effect on the result.
- R6: In the cycle in which `adcCsN` returns high, `rdData` holds the new result and `rdValid` is 1. `rdData` does not change again until the next frame completes.
- R7: A one-cycle `rdEn` clears `rdValid` and `rdOverrun` at the next edge.
- R8: If a frame completes while `rdValid` is still 1 and no `rdEn` is present, `rdOverrun` becomes 1 and `rdData` takes the newer result.
- R9: `dacLoad` is a one-cycle pulse, high in exactly the cycles in which `sampleStb` is high.
- R10: After each strobe, `dacCsN` is low for DAC_BITS periods of `dacSclk` (DAC_DIV cycles each). During that time, `dacSdi` carries the stored DAC word MSB first. Each bit changes as `dacSclk` falls and is stable at its rising edge. The frame ends before the next strobe.
- R11: If no word is written between two strobes, the same word is sent again.
- R12: A word written while a DAC frame is being sent does not change that frame. It is sent in the frame after the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | output | 1 | Fixed-period sample pulse |
| adcCsN | output | 1 | ADC chip select, low starts hold and conversion |
| adcSclk | output | 1 | ADC conversion clock |
| adcSdo | input | 1 | ADC serial data |
| dacCsN | output | 1 | DAC frame select, active low |
| dacSclk | output | 1 | DAC serial clock |
| dacSdi | output | 1 | DAC serial data, MSB first |
| dacLoad | output | 1 | DAC output update pulse |
| rdEn | input | 1 | Read acknowledge, clears valid and overrun |
| rdData | output | ADC_BITS | Last completed ADC result |
| rdValid | output | 1 | Unread result present |
| rdOverrun | output | 1 | A result was overwritten before it was read |
| dacWrEn | input | 1 | Write strobe for the next DAC word |
| dacWrData | input | DAC_BITS | Next DAC word |

## Verification
The strobe and `dacLoad` come from the same register one edge after the divider's terminal count, so the bench measures the gap between strobes on every period. `adcCsN` falls in the same cycle as the strobe. The result and `rdValid` change at the edge that raises `adcCsN` again, 336 cycles later with the default settings, so they are sampled on the falling clock edge in the first cycle in which `adcCsN` reads high. `rdEn` takes effect one edge later, and the flags are checked at the next falling edge. A DAC word sent in one frame is compared when `dacCsN` rises after DAC_BITS rising edges of `dacSclk`.

// File: rtl/fr_seq_pkg.sv
package fr_seq_pkg;
  // strobes from control to datapath, all one system clock wide
  typedef struct packed {
    logic strobe;      // sample instant
    logic adcBit;      // capture adcSdo (conversion clock falling)
    logic adcDone;     // last data bit of the frame
    logic dacLoadWord; // copy pending DAC word into the shifter
    logic dacShift;    // advance DAC shifter (DAC clock falling)
  } seqCtl_t;
endpackage

// File: rtl/fr_seq_sclk.sv
// Serial clock engine: after start, runs BEATS clock periods of DIV system
// clocks each, low half first, and flags the last cycle of every period.
module fr_seq_sclk #(
  parameter int DIV   = 16,
  parameter int BEATS = 21
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output logic busy,
  output logic sclk,
  output logic beatEnd,
  output logic lastBeat,
  output logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] beatIdx
);
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IW   = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int HALF = DIV / 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      phase   <= '0;
      beatIdx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      phase   <= '0;
      beatIdx <= '0;
    end else if (busy) begin
      if (phase == PW'(DIV - 1)) begin
        phase <= '0;
        if (beatIdx == IW'(BEATS - 1)) busy <= 1'b0;
        else beatIdx <= beatIdx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    sclk     = busy && (phase >= PW'(HALF));
    beatEnd  = busy && (phase == PW'(DIV - 1));
    lastBeat = beatEnd && (beatIdx == IW'(BEATS - 1));
  end
endmodule

// File: rtl/fr_seq_ctrl.sv
module fr_seq_ctrl
  import fr_seq_pkg::*;
#(
  parameter int SAMPLE_DIV = 1000,
  parameter int CONV_DIV   = 16,
  parameter int ADC_LEAD   = 5,
  parameter int ADC_BITS   = 16,
  parameter int DAC_DIV    = 4,
  parameter int DAC_BITS   = 16
) (
  input  logic    clk,
  input  logic    rstN,
  output seqCtl_t ctl,
  output logic    sampleStb,
  output logic    adcCsN,
  output logic    adcSclk,
  output logic    dacCsN,
  output logic    dacSclk
);
  localparam int SW        = $clog2(SAMPLE_DIV);
  localparam int ADC_FRAME = ADC_LEAD + ADC_BITS;
  localparam int AIW       = (ADC_FRAME > 1) ? $clog2(ADC_FRAME) : 1;
  localparam int DIW       = (DAC_BITS > 1) ? $clog2(DAC_BITS) : 1;

  logic [SW-1:0] sampCnt;
  logic          tick;
  logic          stbQ;
  logic          adcBusy, adcBeatEnd, adcLast;
  logic          dacBusy, dacBeatEnd, dacLast;
  logic [AIW-1:0] adcIdx;
  logic [DIW-1:0] dacIdx;

  assign tick = (sampCnt == SW'(SAMPLE_DIV - 1));

  // single divider: period is exactly SAMPLE_DIV clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampCnt <= '0;
      stbQ    <= 1'b0;
    end else begin
      sampCnt <= tick ? '0 : sampCnt + 1'b1;
      stbQ    <= tick;
    end
  end

  fr_seq_sclk #(.DIV(CONV_DIV), .BEATS(ADC_FRAME)) adcClk_i (
    .clk(clk), .rstN(rstN), .start(tick),
    .busy(adcBusy), .sclk(adcSclk), .beatEnd(adcBeatEnd),
    .lastBeat(adcLast), .beatIdx(adcIdx)
  );

  fr_seq_sclk #(.DIV(DAC_DIV), .BEATS(DAC_BITS)) dacClk_i (
    .clk(clk), .rstN(rstN), .start(tick),
    .busy(dacBusy), .sclk(dacSclk), .beatEnd(dacBeatEnd),
    .lastBeat(dacLast), .beatIdx(dacIdx)
  );

  always_comb begin
    ctl.strobe      = stbQ;
    ctl.adcBit      = adcBeatEnd && (adcIdx >= AIW'(ADC_LEAD));
    ctl.adcDone     = adcLast;
    ctl.dacLoadWord = tick;
    ctl.dacShift    = dacBeatEnd && !dacLast;
    sampleStb       = stbQ;
    adcCsN          = !adcBusy;
    dacCsN          = !dacBusy;
  end

  p_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |=> !stbQ);
  p_cs_on_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |-> !adcCsN);
  p_adc_idle_before_r3: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |-> $past(adcCsN));
  p_dac_idle_before_r10: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |-> $past(dacCsN));
  p_done_in_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    adcLast |-> (adcSclk && !adcCsN));
endmodule

// File: rtl/fr_seq_data.sv
module fr_seq_data
  import fr_seq_pkg::*;
#(
  parameter int ADC_BITS = 16,
  parameter int DAC_BITS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic                adcSdo,
  input  logic                rdEn,
  input  logic                dacWrEn,
  input  logic [DAC_BITS-1:0] dacWrData,
  output logic [ADC_BITS-1:0] rdData,
  output logic                rdValid,
  output logic                rdOverrun,
  output logic                dacSdi
);
  logic [ADC_BITS-1:0] adcShift;
  logic [DAC_BITS-1:0] dacNext;
  logic [DAC_BITS-1:0] dacShiftReg;

  // ADC capture and holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcShift  <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
      rdOverrun <= 1'b0;
    end else begin
      if (ctl.adcBit) adcShift <= {adcShift[ADC_BITS-2:0], adcSdo};
      if (ctl.adcDone) begin
        rdData    <= {adcShift[ADC_BITS-2:0], adcSdo};
        rdValid   <= 1'b1;
        rdOverrun <= (rdValid && !rdEn) || (rdOverrun && !rdEn);
      end else if (rdEn) begin
        rdValid   <= 1'b0;
        rdOverrun <= 1'b0;
      end
    end
  end

  // DAC pending word and output shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacNext     <= '0;
      dacShiftReg <= '0;
    end else begin
      if (dacWrEn) dacNext <= dacWrData;
      if (ctl.dacLoadWord) dacShiftReg <= dacNext;
      else if (ctl.dacShift) dacShiftReg <= {dacShiftReg[DAC_BITS-2:0], 1'b0};
    end
  end

  assign dacSdi = dacShiftReg[DAC_BITS-1];

  p_valid_on_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.adcDone |=> rdValid);
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.adcDone |=> $stable(rdData));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !ctl.adcDone) |=> (!rdValid && !rdOverrun));
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.adcDone && rdValid && !rdEn) |=> rdOverrun);
  p_dac_bit_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.dacLoadWord && !ctl.dacShift) |=> $stable(dacSdi));
endmodule

// File: rtl/fixed_rate_sampler.sv
module fixed_rate_sampler
  import fr_seq_pkg::*;
#(
  parameter int SAMPLE_DIV = 1000,
  parameter int CONV_DIV   = 16,
  parameter int ADC_LEAD   = 5,
  parameter int ADC_BITS   = 16,
  parameter int DAC_DIV    = 4,
  parameter int DAC_BITS   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  output logic                sampleStb,
  output logic                adcCsN,
  output logic                adcSclk,
  input  logic                adcSdo,
  output logic                dacCsN,
  output logic                dacSclk,
  output logic                dacSdi,
  output logic                dacLoad,
  input  logic                rdEn,
  output logic [ADC_BITS-1:0] rdData,
  output logic                rdValid,
  output logic                rdOverrun,
  input  logic                dacWrEn,
  input  logic [DAC_BITS-1:0] dacWrData
);
  seqCtl_t ctl;

  fr_seq_ctrl #(
    .SAMPLE_DIV(SAMPLE_DIV), .CONV_DIV(CONV_DIV), .ADC_LEAD(ADC_LEAD),
    .ADC_BITS(ADC_BITS), .DAC_DIV(DAC_DIV), .DAC_BITS(DAC_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleStb(sampleStb),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .dacCsN(dacCsN), .dacSclk(dacSclk)
  );

  fr_seq_data #(.ADC_BITS(ADC_BITS), .DAC_BITS(DAC_BITS)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adcSdo(adcSdo), .rdEn(rdEn),
    .dacWrEn(dacWrEn), .dacWrData(dacWrData), .rdData(rdData),
    .rdValid(rdValid), .rdOverrun(rdOverrun), .dacSdi(dacSdi)
  );

  assign dacLoad = ctl.strobe;
endmodule

// File: tb/fixed_rate_sampler_tb_top.sv
module fixed_rate_sampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_DIV = 1000;
  localparam int CONV_DIV   = 16;
  localparam int ADC_LEAD   = 5;
  localparam int ADC_BITS   = 16;
  localparam int DAC_DIV    = 4;
  localparam int DAC_BITS   = 16;
  localparam int ADC_FRAME  = ADC_LEAD + ADC_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb, adcCsN, adcSclk, dacCsN, dacSclk, dacSdi, dacLoad;
  logic adcSdo = 1'b1;
  logic rdEn = 1'b0;
  logic [ADC_BITS-1:0] rdData;
  logic rdValid, rdOverrun;
  logic dacWrEn = 1'b0;
  logic [DAC_BITS-1:0] dacWrData = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_rate_sampler #(
    .SAMPLE_DIV(SAMPLE_DIV), .CONV_DIV(CONV_DIV), .ADC_LEAD(ADC_LEAD),
    .ADC_BITS(ADC_BITS), .DAC_DIV(DAC_DIV), .DAC_BITS(DAC_BITS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .adcCsN(adcCsN),
    .adcSclk(adcSclk), .adcSdo(adcSdo), .dacCsN(dacCsN), .dacSclk(dacSclk),
    .dacSdi(dacSdi), .dacLoad(dacLoad), .rdEn(rdEn), .rdData(rdData),
    .rdValid(rdValid), .rdOverrun(rdOverrun), .dacWrEn(dacWrEn),
    .dacWrData(dacWrData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- ADC model and frame monitors ----------------
  logic [ADC_BITS-1:0] adcNextWord = '0;
  logic [ADC_BITS-1:0] adcCurWord = '0;
  logic prevAdcCs = 1'b1, prevAdcSclk = 1'b0;
  int adcEdges = 0, adcLowCnt = 0;
  logic prevDacCs = 1'b1, prevDacSclk = 1'b0;
  int dacBits = 0, dacFrames = 0;
  logic [DAC_BITS-1:0] dacRx = '0, lastDac = '0;
  int stbGap = 0;
  bit stbSeen = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      // R1 / R9: strobe period and load pulse
      if (sampleStb) begin
        if (stbSeen) chk(stbGap + 1 == SAMPLE_DIV, "R1 strobe period", stbGap + 1, SAMPLE_DIV);
        chk(dacLoad, "R9 load with strobe", dacLoad, 1);
        stbGap  = 0;
        stbSeen = 1'b1;
      end else begin
        stbGap++;
        if (dacLoad) chk(1'b0, "R9 load without strobe", 1, 0);
      end
      // ADC frame
      if (!adcCsN && prevAdcCs) begin
        chk(sampleStb, "R3 cs falls with strobe", sampleStb, 1);
        adcEdges   = 0;
        adcLowCnt  = 1;
        adcCurWord = adcNextWord;
      end else if (!adcCsN) begin
        adcLowCnt++;
      end
      if (adcSclk && !prevAdcSclk) begin
        adcEdges++;
        if (adcEdges > ADC_LEAD) adcSdo = adcCurWord[ADC_BITS-1-(adcEdges-ADC_LEAD-1)];
        else adcSdo = 1'b1; // lead-in clocks carry junk
      end
      if (adcCsN && adcSclk) chk(1'b0, "R4 sclk idle", 1, 0);
      if (adcCsN && !prevAdcCs) begin
        chk(adcEdges == ADC_FRAME, "R4 conversion clock count", adcEdges, ADC_FRAME);
        chk(adcLowCnt == ADC_FRAME * CONV_DIV, "R3 cs low length", adcLowCnt, ADC_FRAME * CONV_DIV);
      end
      prevAdcCs   = adcCsN;
      prevAdcSclk = adcSclk;
      // DAC frame
      if (!dacCsN && prevDacCs) begin
        chk(sampleStb, "R10 DAC frame starts at strobe", sampleStb, 1);
        dacBits = 0;
      end
      if (dacSclk && !prevDacSclk && !dacCsN) begin
        dacRx = {dacRx[DAC_BITS-2:0], dacSdi};
        dacBits++;
      end
      if (dacCsN && !prevDacCs) begin
        chk(dacBits == DAC_BITS, "R10 DAC bit count", dacBits, DAC_BITS);
        lastDac = dacRx;
        dacFrames++;
      end
      prevDacCs   = dacCsN;
      prevDacSclk = dacSclk;
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_strobe();
    @(negedge clk);
    while (!sampleStb) @(negedge clk);
  endtask

  task automatic wait_adc_end();
    logic p;
    p = adcCsN;
    forever begin
      @(negedge clk);
      if (adcCsN && !p) break;
      p = adcCsN;
    end
  endtask

  task automatic wait_dac_end();
    int f;
    f = dacFrames;
    while (dacFrames == f) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic dac_write(input logic [DAC_BITS-1:0] w);
    @(negedge clk);
    dacWrEn = 1'b1;
    dacWrData = w;
    @(negedge clk);
    dacWrEn = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(adcCsN && dacCsN, "R2 chip selects high", {adcCsN, dacCsN}, 2'b11);
    chk(!adcSclk && !dacSclk, "R2 clocks low", {adcSclk, dacSclk}, 0);
    chk(!sampleStb && !dacLoad, "R2 strobes low", {sampleStb, dacLoad}, 0);
    chk(!rdValid && !rdOverrun, "R2 flags low", {rdValid, rdOverrun}, 0);
    chk(rdData == '0, "R2 data zero", rdData, 0);
    rstN = 1'b1;
  endtask

  task automatic t_adc_result(input logic [ADC_BITS-1:0] w, input string tag);
    adcNextWord = w;
    wait_adc_end();
    chk(rdValid, {"R6 valid at frame end ", tag}, rdValid, 1);
    chk(rdData == w, {"R5 result ", tag}, rdData, w);
    repeat (20) @(negedge clk);
    chk(rdData == w, {"R6 result held ", tag}, rdData, w);
    do_read();
    chk(!rdValid && !rdOverrun, {"R7 read clears ", tag}, {rdValid, rdOverrun}, 0);
  endtask

  task automatic t_overrun();
    adcNextWord = 16'h1357;
    wait_adc_end();
    chk(!rdOverrun, "R8 no overrun after one frame", rdOverrun, 0);
    adcNextWord = 16'hFACE;
    wait_adc_end();
    chk(rdOverrun, "R8 overrun set", rdOverrun, 1);
    chk(rdData == 16'hFACE, "R8 newer result kept", rdData, 16'hFACE);
    do_read();
    chk(!rdValid && !rdOverrun, "R7 read clears overrun", {rdValid, rdOverrun}, 0);
  endtask

  task automatic t_dac();
    // write while idle, sent in the next frame
    dac_write(16'h1234);
    wait_strobe();
    wait_dac_end();
    chk(lastDac == 16'h1234, "R10 DAC word sent", lastDac, 16'h1234);
    // next frame without a write: resend; write during the shift
    wait_strobe();
    repeat (3) @(negedge clk);
    chk(!dacCsN, "R12 write lands inside frame", dacCsN, 0);
    dac_write(16'hBEEF);
    wait_dac_end();
    chk(lastDac == 16'h1234, "R11 R12 old word resent", lastDac, 16'h1234);
    wait_strobe();
    wait_dac_end();
    chk(lastDac == 16'hBEEF, "R12 new word in following frame", lastDac, 16'hBEEF);
    wait_strobe();
    wait_dac_end();
    chk(lastDac == 16'hBEEF, "R11 repeat without write", lastDac, 16'hBEEF);
  endtask

  initial begin
    t_reset();
    t_adc_result(16'hA5C3, "pattern");
    t_adc_result(16'h0000, "zero with junk lead-in");
    t_adc_result(16'h8001, "edges");
    t_adc_result(16'h7FFE, "inverse edges");
    t_overrun();
    t_dac();
    repeat (10) @(negedge clk);
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_sim();
  end
endmodule